// File: doc/BRIEF.md
# Symmetric Fourth-Order Bit-Serial FIR Section

This block is one linear-phase fourth-order FIR stage, meant to be chained with identical stages to build a long filter in cascade form. It keeps the last five accepted samples. The filter is symmetric, so the outer pair of samples and the inner pair of samples are each summed before any coefficient is applied. The section then needs only three coefficients, `C0` (outer pair), `C1` (inner pair) and `C2` (centre sample).

The arithmetic is bit-serial distributed arithmetic. For each bit position, least significant bit first, two one-bit serial adders form one bit of each pair sum. Those two bits and one bit of the centre sample form a 3-bit address into an 8-entry table of coefficient sums. A scaling accumulator weights each table word by its bit position. On the sign position it subtracts the word instead of adding it.

The finished sum is rounded and saturated back to the sample width, so the result can feed the next section directly. An optional register after the table shortens the critical path at the cost of one cycle. Alignment flags travel with the data through every pipeline register, so the serial phase and the accumulator always agree on which bit they hold.

Top module: `sym4_da_section`

## Requirements
- R1: Samples and `out_data` are DW-bit two's complement. Coefficients are signed integers with FRAC fractional bits. Take x0 as the newest accepted sample and x4 as the oldest. The result is `floor((C0*(x0+x4) + C1*(x1+x3) + C2*x2 + 2^(FRAC-1)) / 2^FRAC)`, saturated to the DW-bit signed range.
- R2: Reset clears the five-sample history to zero. The first result after reset therefore depends only on the sample just accepted.
- R3: A sample is accepted at a rising edge where `in_valid` and `in_ready` are both high. `out_valid` rises exactly PER = DW+2+TBL_REG edges later, stays high for one cycle, and is never raised without a matching accept.
- R4: For PER-1 cycles after an accept, `in_ready` is low. Any `in_valid` asserted in that window is ignored and changes neither the history nor any result.
- R5: `in_ready` is high again PER-1 cycles after an accept. A new sample can therefore be taken every PER cycles, back to back, and each result stays correct.
- R6: `out_data` holds its value in every cycle in which `out_valid` is low.
- R7: During and straight after reset, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1.
- R8: Results stay correct for full-scale samples, including the most negative value in every tap position and long runs of it. No serial-adder carry or accumulator state carries over from one sample into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Offers `in_data` as the next sample |
| in_data | input | DW | Sample, two's complement |
| in_ready | output | 1 | High when a sample can be accepted |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | DW | Rounded, saturated section output |

## Verification
Each result is due exactly PER rising edges after its sample is accepted. With the default width and table register this is 11 edges. The bench records the edge count at every accept and queues the expected value with that due count. A monitor samples on the falling edge and flags a result that arrives early, arrives late or is missing.

The busy window is checked on the same falling-edge grid: `in_ready` must be low from the accept through PER-1 cycles and high in the cycle just before the result edge. The history model changes only when an accept happens, so a stray `in_valid` during the busy window would show up as a wrong value eleven edges later.

// File: rtl/sym4_da_pkg.sv
`timescale 1ns/1ps
package sym4_da_pkg;

   // Alignment flags that travel alongside the serial data.
   typedef struct packed {
      logic first;   // lowest bit position of a sample
      logic last;    // sign bit position of a sample
      logic act;     // slot carries a live bit
   } tag_t;

   // Coefficient sum selected by one 3-bit table address.
   // Address bit 2: outer pair, bit 1: inner pair, bit 0: centre sample.
   function automatic int lut_entry(input int addr, input int c0, input int c1, input int c2);
      int acc;
      acc = 0;
      if (addr[2]) acc = acc + c0;
      if (addr[1]) acc = acc + c1;
      if (addr[0]) acc = acc + c2;
      return acc;
   endfunction

endpackage

// File: rtl/sym4_da_serial.sv
`timescale 1ns/1ps
module sym4_da_serial
   import sym4_da_pkg::*;
#(
   parameter int DW = 8,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   input  logic          act,
   input  logic          first,
   input  logic          last,
   input  logic [IW-1:0] bit_idx,
   output logic [2:0]    addr_q,
   output tag_t          tag_q
);
   localparam int TAPS  = 5;
   localparam int NPAIR = 2;

   logic [DW-1:0]    tap [TAPS];
   logic [IW-1:0]    sel;
   logic [TAPS-1:0]  bt;
   logic [NPAIR-1:0] psum;

   // Five-sample history; the newest sample sits in tap[0].
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TAPS; i++) tap[i] <= '0;
      end else if (load) begin
         tap[0] <= din;
         for (int i = 1; i < TAPS; i++) tap[i] <= tap[i-1];
      end
   end

   // Past the top bit, repeat the sign bit so each pair sum gains its extra bit.
   assign sel = (bit_idx >= IW'(DW)) ? IW'(DW-1) : bit_idx;

   generate
      for (genvar i = 0; i < TAPS; i++) begin : g_bit
         assign bt[i] = tap[i][sel];
      end

      // One-bit serial adders: pair p adds tap p to its mirror tap.
      for (genvar p = 0; p < NPAIR; p++) begin : g_pair
         logic cy_r;
         logic ci;
         logic co;
         logic a;
         logic b;
         assign a       = bt[p];
         assign b       = bt[TAPS-1-p];
         assign ci      = first ? 1'b0 : cy_r;
         assign psum[p] = a ^ b ^ ci;
         assign co      = (a & b) | (ci & (a ^ b));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cy_r <= 1'b0;
            else if (act) cy_r <= co;
         end
      end
   endgenerate

   // First pipeline stage: the table address and its alignment flags.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         tag_q  <= '0;
      end else begin
         addr_q <= {psum[0], psum[1], bt[2]};
         tag_q  <= '{first: first, last: last, act: act};
      end
   end
endmodule

// File: rtl/sym4_da_lut.sv
`timescale 1ns/1ps
module sym4_da_lut
   import sym4_da_pkg::*;
#(
   parameter int TW      = 12,
   parameter int C0      = 0,
   parameter int C1      = 0,
   parameter int C2      = 0,
   parameter int TBL_REG = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           addr,
   input  tag_t                 tag_in,
   output logic signed [TW-1:0] val,
   output tag_t                 tag_out
);
   localparam int ENTRIES = 8;

   logic signed [TW-1:0] tbl [ENTRIES];
   logic signed [TW-1:0] word;

   generate
      for (genvar a = 0; a < ENTRIES; a++) begin : g_entry
         assign tbl[a] = TW'(lut_entry(a, C0, C1, C2));
      end
   endgenerate

   assign word = tbl[addr];

   generate
      if (TBL_REG != 0) begin : g_reg
         // Added stage; the flags take an alignment register of their own.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val     <= '0;
               tag_out <= '0;
            end else begin
               val     <= word;
               tag_out <= tag_in;
            end
         end
      end else begin : g_comb
         assign val     = word;
         assign tag_out = tag_in;
      end
   endgenerate
endmodule

// File: rtl/sym4_da_acc.sv
`timescale 1ns/1ps
module sym4_da_acc
   import sym4_da_pkg::*;
#(
   parameter int DW   = 8,
   parameter int TW   = 12,
   parameter int FRAC = 8,
   parameter int NB   = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [TW-1:0] t_val,
   input  tag_t                 tag,
   output logic                 out_valid,
   output logic [DW-1:0]        out_data
);
   localparam int UW = TW + 2;           // headroom for the partial sum
   localparam int PW = UW + NB;          // full-precision result
   localparam logic signed [PW:0] HALF   = (PW+1)'(1) <<< (FRAC-1);
   localparam logic signed [PW:0] SAT_HI = ((PW+1)'(1) <<< (DW-1)) - (PW+1)'(1);
   localparam logic signed [PW:0] SAT_LO = -SAT_HI - (PW+1)'(1);

   logic signed [PW-1:0] p_q;
   logic signed [PW-1:0] p_nxt;
   logic signed [UW-1:0] hi;
   logic signed [UW-1:0] t_ext;
   logic signed [UW-1:0] term;
   logic signed [UW-1:0] sum;
   logic [NB-1:0]        lo;
   logic [PW:0]          wide;
   logic signed [PW:0]   p_ext;
   logic signed [PW:0]   rnd;
   logic [DW-1:0]        sat;

   assign hi    = tag.first ? '0 : p_q[PW-1:NB];
   assign lo    = tag.first ? '0 : p_q[NB-1:0];
   assign t_ext = UW'(t_val);
   assign term  = tag.last ? -t_ext : t_ext;   // sign position is subtracted
   assign sum   = hi + term;
   assign wide  = {sum[UW-1], sum, lo};
   assign p_nxt = PW'($signed(wide) >>> 1);

   assign p_ext = (PW+1)'(p_nxt);
   assign rnd   = (p_ext + HALF) >>> FRAC;

   always_comb begin
      if (rnd > SAT_HI)      sat = SAT_HI[DW-1:0];
      else if (rnd < SAT_LO) sat = SAT_LO[DW-1:0];
      else                   sat = rnd[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q       <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= tag.act & tag.last;
         if (tag.act) p_q <= p_nxt;
         if (tag.act & tag.last) out_data <= sat;
      end
   end
endmodule

// File: rtl/sym4_da_section.sv
`timescale 1ns/1ps
module sym4_da_section
   import sym4_da_pkg::*;
#(
   parameter int DW      = 8,
   parameter int CW      = 10,
   parameter int FRAC    = 8,
   parameter int C0      = -20,
   parameter int C1      = 70,
   parameter int C2      = 156,
   parameter int TBL_REG = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          in_ready,
   output logic          out_valid,
   output logic [DW-1:0] out_data
);
   localparam int NB     = DW + 1;               // serial word with the pair-sum bit
   localparam int PER    = NB + 1 + TBL_REG;     // cycles per sample
   localparam int CNTW   = $clog2(PER);
   localparam int TW     = CW + 2;
   localparam int CMAX   = (1 << (CW-1)) - 1;
   localparam int CMIN   = -(1 << (CW-1));

   generate
      if (DW < 2 || DW > 24)                $error("DW out of range");
      if (CW < 2 || CW > 24)                $error("CW out of range");
      if (FRAC < 1 || FRAC > CW + DW)       $error("FRAC out of range");
      if (TBL_REG != 0 && TBL_REG != 1)     $error("TBL_REG must be 0 or 1");
      if (C0 > CMAX || C0 < CMIN)           $error("C0 does not fit CW bits");
      if (C1 > CMAX || C1 < CMIN)           $error("C1 does not fit CW bits");
      if (C2 > CMAX || C2 < CMIN)           $error("C2 does not fit CW bits");
   endgenerate

   logic            busy;
   logic [CNTW-1:0] cnt;
   logic            accept;
   logic            ser_act;
   logic            ser_first;
   logic            ser_last;
   logic [2:0]      addr_q;
   tag_t            tag_a;
   tag_t            tag_b;
   logic signed [TW-1:0] t_val;

   assign in_ready  = !busy || (cnt == CNTW'(PER-1));
   assign accept    = in_valid && in_ready;
   assign ser_act   = busy && (cnt < CNTW'(NB));
   assign ser_first = ser_act && (cnt == '0);
   assign ser_last  = ser_act && (cnt == CNTW'(NB-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == CNTW'(PER-1)) busy <= 1'b0;
         else                     cnt  <= cnt + 1'b1;
      end
   end

   sym4_da_serial #(.DW(DW), .IW(CNTW)) u_serial (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .din     (in_data),
      .act     (ser_act),
      .first   (ser_first),
      .last    (ser_last),
      .bit_idx (cnt),
      .addr_q  (addr_q),
      .tag_q   (tag_a)
   );

   sym4_da_lut #(.TW(TW), .C0(C0), .C1(C1), .C2(C2), .TBL_REG(TBL_REG)) u_lut (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr_q),
      .tag_in  (tag_a),
      .val     (t_val),
      .tag_out (tag_b)
   );

   sym4_da_acc #(.DW(DW), .TW(TW), .FRAC(FRAC), .NB(NB)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .t_val     (t_val),
      .tag       (tag_b),
      .out_valid (out_valid),
      .out_data  (out_data)
   );
endmodule

// File: rtl/sym4_da_section_chk.sv
`timescale 1ns/1ps
module sym4_da_section_chk #(
   parameter int DW      = 8,
   parameter int TBL_REG = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic          out_valid,
   input logic [DW-1:0] out_data
);
   localparam int PER = DW + 2 + TBL_REG;
   localparam int DCW = $clog2(PER + 1);

   // Counts down from PER at each accept; 1 means the result is due next edge.
   logic [DCW-1:0] due;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    due <= '0;
      else if (in_valid && in_ready) due <= DCW'(PER);
      else if (due != '0)            due <= due - 1'b1;
   end

   AST_OUT_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      (due == DCW'(1)) |=> out_valid);                              // R3
   AST_NO_STRAY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(due) == DCW'(1)));                       // R3
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);                                    // R3
   AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (due > DCW'(1)) |-> !in_ready);                               // R4
   AST_READY_AGAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (due <= DCW'(1)) |-> in_ready);                               // R5
   AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));                            // R6
endmodule

bind sym4_da_section sym4_da_section_chk #(.DW(DW), .TBL_REG(TBL_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/sym4_da_section_bench.sv
`timescale 1ns/1ps
module sym4_da_section_bench;
   localparam int DW      = 8;
   localparam int CW      = 10;
   localparam int FRAC    = 8;
   localparam int C0      = -20;
   localparam int C1      = 70;
   localparam int C2      = 156;
   localparam int TBL_REG = 1;
   localparam int PER     = DW + 2 + TBL_REG;
   localparam int QD      = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_ready;
   logic          out_valid;
   logic [DW-1:0] out_data;

   sym4_da_section #(.DW(DW), .CW(CW), .FRAC(FRAC), .C0(C0), .C1(C1), .C2(C2),
                     .TBL_REG(TBL_REG)) u_sym4_da_section (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data));

   always #10 clk = ~clk;   // 20 ns period, 50 MHz

   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc = 0;
   int    hist [5];
   int    exp_q [QD];
   int    due_q [QD];
   int    wr = 0;
   int    rd = 0;
   bit    mon_on = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R1";
   logic [DW-1:0] last_out = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic int model();
      int y;
      y = C0 * (hist[0] + hist[4]) + C1 * (hist[1] + hist[3]) + C2 * hist[2];
      y = (y + (1 << (FRAC-1))) >>> FRAC;
      if (y > (1 << (DW-1)) - 1) y = (1 << (DW-1)) - 1;
      if (y < -(1 << (DW-1)))    y = -(1 << (DW-1));
      return y;
   endfunction

   // Result monitor on the falling edge: value, due edge and hold between pulses.
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         if (out_valid) begin
            if (rd == wr) chk(1'b0, "R3 result without accept", 1, 0);
            else begin
               chk(cyc == due_q[rd % QD], "R3 result edge", cyc, due_q[rd % QD]);
               chk($signed(out_data) == exp_q[rd % QD], {cur_req, " result value"},
                   int'($signed(out_data)), exp_q[rd % QD]);
               rd++;
            end
            last_out = out_data;
         end else begin
            chk(out_data == last_out, "R6 held output", int'(out_data), int'(last_out));
            if (rd != wr && cyc >= due_q[rd % QD]) begin
               chk(1'b0, "R3 missing result", cyc, due_q[rd % QD]);
               rd++;
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Called on a falling edge with in_ready high; returns PER-1 cycles after the accept.
   task automatic run_sample(input int v, input bit junk);
      chk(in_ready == 1'b1, "R5 ready before sample", int'(in_ready), 1);
      in_valid = 1'b1;
      in_data  = DW'(v);
      @(negedge clk);
      for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = v;
      exp_q[wr % QD] = model();
      due_q[wr % QD] = cyc + PER;
      wr++;
      in_valid = junk;          // R4: offered while busy, must be ignored
      in_data  = ~DW'(v);
      for (int j = 0; j < PER - 1; j++) begin
         chk(in_ready == 1'b0, "R4 busy window", int'(in_ready), 0);
         if (j == PER - 2) in_valid = 1'b0;
         @(negedge clk);
      end
      chk(in_ready == 1'b1, "R5 ready after period", int'(in_ready), 1);
   endtask

   task automatic reset_phase();
      rst_n = 1'b0;
      mon_on = 1'b0;
      in_valid = 1'b0;
      idle(3);
      chk(out_valid == 1'b0, "R7 reset out_valid", int'(out_valid), 0);
      chk(out_data == '0, "R7 reset out_data", int'(out_data), 0);
      chk(in_ready == 1'b1, "R7 reset in_ready", int'(in_ready), 1);
      for (int i = 0; i < 5; i++) hist[i] = 0;
      last_out = '0;
      rd = wr;
      rst_n = 1'b1;
      idle(1);
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R7 state after release",
          int'({out_valid, in_ready}), 1);
      mon_on = 1'b1;
   endtask

   initial begin
      for (int i = 0; i < 5; i++) hist[i] = 0;
      idle(1);
      reset_phase();

      // R2: first result after reset sees an all-zero history.
      cur_req = "R2";
      run_sample(100, 1'b0);
      run_sample(-37, 1'b0);

      // R1 / R4 / R5: every sample value back to back, junk offered on some.
      cur_req = "R1";
      for (int v = -(1 << (DW-1)); v < (1 << (DW-1)); v++) begin
         if ((v & 15) == 0) idle(2);
         run_sample(v, (v % 3) == 0);
      end

      // R8: full-scale runs, alternations and a flush with zeros.
      cur_req = "R8";
      for (int k = 0; k < 6; k++) run_sample(-(1 << (DW-1)), 1'b1);
      for (int k = 0; k < 6; k++) run_sample((1 << (DW-1)) - 1, 1'b0);
      for (int k = 0; k < 10; k++) run_sample((k % 2) ? (1 << (DW-1)) - 1 : -(1 << (DW-1)), 1'b0);
      for (int k = 0; k < 6; k++) run_sample(-1, 1'b1);
      for (int k = 0; k < 5; k++) run_sample(0, 1'b0);
      idle(PER + 3);
      chk(rd == wr, "R3 all results delivered", rd, wr);

      // R2 / R7: reset in the middle of a run clears the history.
      reset_phase();
      cur_req = "R2";
      run_sample(-(1 << (DW-1)), 1'b0);
      run_sample(55, 1'b1);
      idle(PER + 3);
      chk(rd == wr, "R3 all results delivered after reset", rd, wr);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule